// File: doc/BRIEF.md
# Nibble-Offset Packet Pattern Matcher

The block watches a frame that arrives as a stream of 4-bit nibbles, starting with the first nibble after the start-of-frame delimiter. It decides whether a masked pattern of up to 24 bits sits at a programmed nibble offset. A frame counts as matched when every bit that is not masked off agrees with the programmed pattern. Only then is the time value latched at the delimiter-done pulse released as a timestamp. This lets a host timestamp selected message types, for example one precision-time message class, instead of every frame.

Each nibble is accepted on a cycle where `nib_valid` is high. The block never applies back-pressure: `nib_ready` stays high, so every nibble offered is taken in that cycle, and an upstream source may insert idle cycles freely. The frame-start and frame-end strobes and the delimiter-done pulse are plain single-cycle control pins. The configuration inputs are expected to stay steady while a frame is in flight.

Top module: `pkt_pattern_matcher`

## Requirements
- R1: `nib_ready` is high in every cycle after reset, so no nibble offered with `nib_valid` is ever held off.
- R2: The location value counts nibbles received since frame start and names the first nibble after the compared window. The comparison uses the six nibbles numbered location-6 through location-1, with nibble 0 being the first after the delimiter. Window slots before nibble 0 read as zero.
- R3: Within each byte the low nibble arrives first. The window is compared in byte order with the high nibble first, so for a window covering nibbles 24..29 the 24-bit word is {n25,n24,n27,n26,n29,n28}.
- R4: A mask bit of 1 makes the matching pattern bit a don't-care. A mask bit of 0 requires an exact match, so an all-zero mask compares all 24 bits.
- R5: `cfg_pat_hi`/`cfg_msk_hi` supply bits 23:16 of the pattern and mask, and `cfg_pat_lo`/`cfg_msk_lo` supply bits 15:0.
- R6: When `cfg_enable` is low, `match_flag` and `ts_valid` stay low for every frame.
- R7: With location 0 and mask 0xFFFFFF, every frame matches, including a frame with no nibbles.
- R8: A frame whose end strobe comes before the location count is reached is reported as not matched. Nibbles offered after the end strobe are ignored.
- R9: `match_flag` is cleared by the frame-start strobe. A nibble offered in that same cycle is ignored. Once set, the flag holds until the next frame-start strobe.
- R10: `ts_time` takes the value of `time_now` on each `sfd_done` pulse and holds it until the next pulse, whether or not the frame matches.
- R11: `ts_valid` pulses for exactly one cycle per matched frame, in the same cycle that `match_flag` rises, and never for an unmatched frame.
- R12: The comparison is made once per frame, one cycle after the count equals the location. Nibbles received afterwards do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nib_valid | input | 1 | Nibble offered this cycle |
| nib_ready | output | 1 | Nibble accepted (always high) |
| nib_data | input | 4 | Frame nibble, low nibble of each byte first |
| frm_start | input | 1 | Single-cycle strobe before the first nibble of a frame |
| frm_end | input | 1 | Single-cycle strobe after the last nibble of a frame |
| sfd_done | input | 1 | Pulse marking the end of the delimiter on the medium |
| time_now | input | TIME_W | Free-running time value |
| cfg_enable | input | 1 | Matcher enable |
| cfg_loc | input | LOC_W | Nibble count just past the compared window |
| cfg_pat_hi | input | 8 | Pattern bits 23:16 |
| cfg_pat_lo | input | 16 | Pattern bits 15:0 |
| cfg_msk_hi | input | 8 | Ignore-mask bits 23:16 |
| cfg_msk_lo | input | 16 | Ignore-mask bits 15:0 |
| match_flag | output | 1 | Current frame matched |
| ts_valid | output | 1 | One-cycle strobe releasing the timestamp |
| ts_time | output | TIME_W | Time latched at the last delimiter-done pulse |

## Verification
The main directed frame places the message-type bytes 0x88, 0xF7, 0x10 at nibbles 24..29 and compares at location 30. Moving the location to 29 or storing the nibbles in the wrong order within a byte must then break the match, which separates correct window placement from nibble-swap errors. Altering one message-type nibble distinguishes an exact compare from a masked one when the low mask nibble is set. Altering the top byte checks that the high and low register halves are placed correctly. Frames shorter than the location, frames exactly as long as the location, location 0 with a full mask, and a disabled matcher cover the edge cases. Random frames with random gaps, locations and masks, whose pattern is often taken from the frame itself, mix matches and near misses.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int NIB_W = 4;
  localparam int PAT_W = 24;
  localparam int WIN_NIBS = PAT_W / NIB_W;
  localparam int WIN_BYTES = WIN_NIBS / 2;
  localparam int HI_W = 8;
  localparam int LO_W = PAT_W - HI_W;

  typedef logic [PAT_W-1:0] word_t;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/pm_nibble_window.sv
module pm_nibble_window
  import pm_pkg::*;
#(
  parameter int LOC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  nib_t             nib,
  output logic [LOC_W-1:0] cnt,
  output word_t            win
);
  localparam logic [LOC_W-1:0] CNT_MAX = {LOC_W{1'b1}};

  word_t sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      sr  <= '0;
      cnt <= '0;
    end else if (shift_en) begin
      sr <= {sr[PAT_W-NIB_W-1:0], nib};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  // The newest nibble sits at the bottom of sr. Swapping each nibble pair puts
  // every byte in high-nibble-first order.
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_swap
    assign win[8*g+7 -: 4] = sr[8*g+3 -: 4];
    assign win[8*g+3 -: 4] = sr[8*g+7 -: 4];
  end

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !shift_en) |=> $stable(cnt) && $stable(win));
endmodule

// File: rtl/pm_masked_cmp.sv
module pm_masked_cmp
  import pm_pkg::*;
(
  input  logic [HI_W-1:0] pat_hi,
  input  logic [LO_W-1:0] pat_lo,
  input  logic [HI_W-1:0] msk_hi,
  input  logic [LO_W-1:0] msk_lo,
  input  word_t           win,
  output logic            equal
);
  word_t pat, msk, diff;

  always_comb begin
    pat   = {pat_hi, pat_lo};
    msk   = {msk_hi, msk_lo};
    diff  = (win ^ pat) & ~msk;
    equal = (diff == '0);
  end
endmodule

// File: rtl/pm_ts_capture.sv
module pm_ts_capture #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfd_done,
  input  logic [TIME_W-1:0] time_now,
  input  logic              fire,
  output logic              ts_valid,
  output logic [TIME_W-1:0] ts_time
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_time  <= '0;
      ts_valid <= 1'b0;
    end else begin
      if (sfd_done) ts_time <= time_now;
      ts_valid <= fire;
    end
  end

  assert_ts_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_done |=> (ts_time == $past(time_now)));
  assert_ts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sfd_done |=> $stable(ts_time));
endmodule

// File: rtl/pkt_pattern_matcher.sv
module pkt_pattern_matcher
  import pm_pkg::*;
#(
  parameter int LOC_W  = 8,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nib_valid,
  output logic              nib_ready,
  input  logic [3:0]        nib_data,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              sfd_done,
  input  logic [TIME_W-1:0] time_now,
  input  logic              cfg_enable,
  input  logic [LOC_W-1:0]  cfg_loc,
  input  logic [7:0]        cfg_pat_hi,
  input  logic [15:0]       cfg_pat_lo,
  input  logic [7:0]        cfg_msk_hi,
  input  logic [15:0]       cfg_msk_lo,
  output logic              match_flag,
  output logic              ts_valid,
  output logic [TIME_W-1:0] ts_time
);
  logic             active, eval_done;
  logic [LOC_W-1:0] cnt;
  word_t            win;
  logic             cmp_equal, eval_hit, shift_en, fire;

  assign nib_ready = 1'b1;
  assign shift_en  = nib_valid && active && !frm_start;
  assign eval_hit  = active && !eval_done && (cnt == cfg_loc) && !frm_start;
  assign fire      = eval_hit && cfg_enable && cmp_equal;

  pm_nibble_window #(.LOC_W(LOC_W)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(frm_start), .shift_en(shift_en),
    .nib(nib_data), .cnt(cnt), .win(win)
  );

  pm_masked_cmp u_cmp (
    .pat_hi(cfg_pat_hi), .pat_lo(cfg_pat_lo),
    .msk_hi(cfg_msk_hi), .msk_lo(cfg_msk_lo),
    .win(win), .equal(cmp_equal)
  );

  pm_ts_capture #(.TIME_W(TIME_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .sfd_done(sfd_done), .time_now(time_now),
    .fire(fire), .ts_valid(ts_valid), .ts_time(ts_time)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      eval_done  <= 1'b0;
      match_flag <= 1'b0;
    end else if (frm_start) begin
      active     <= 1'b1;
      eval_done  <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (frm_end) active <= 1'b0;
      if (eval_hit) begin
        eval_done  <= 1'b1;
        match_flag <= fire;
      end
    end
  end

  assert_ts_needs_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |-> match_flag);
  assert_ts_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> !ts_valid);
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !ts_valid);
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !match_flag && !ts_valid);
  assert_eval_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && !frm_start) |=> $stable(match_flag) && !ts_valid);
endmodule

// File: tb/pkt_pattern_matcher_tb.sv
`timescale 1ns/1ps
module pkt_pattern_matcher_tb;
  logic        clk = 0, rst_n = 0;
  logic        nib_valid = 0, nib_ready;
  logic [3:0]  nib_data = 0;
  logic        frm_start = 0, frm_end = 0, sfd_done = 0;
  logic [31:0] time_now = 0;
  logic        cfg_enable = 0;
  logic [7:0]  cfg_loc = 0;
  logic [7:0]  cfg_pat_hi = 0, cfg_msk_hi = 0;
  logic [15:0] cfg_pat_lo = 0, cfg_msk_lo = 0;
  logic        match_flag, ts_valid;
  logic [31:0] ts_time;

  int checks = 0, fails = 0, ts_cnt = 0;
  logic [31:0] exp_ts = 0;
  logic [3:0] fr [64];

  always #2.5 clk = ~clk;
  always @(posedge clk) time_now <= time_now + 32'd1;

  pkt_pattern_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib_ready(nib_ready),
    .nib_data(nib_data), .frm_start(frm_start), .frm_end(frm_end),
    .sfd_done(sfd_done), .time_now(time_now), .cfg_enable(cfg_enable),
    .cfg_loc(cfg_loc), .cfg_pat_hi(cfg_pat_hi), .cfg_pat_lo(cfg_pat_lo),
    .cfg_msk_hi(cfg_msk_hi), .cfg_msk_lo(cfg_msk_lo),
    .match_flag(match_flag), .ts_valid(ts_valid), .ts_time(ts_time)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] window_of(input int loc);
    logic [3:0] s [6];
    for (int j = 0; j < 6; j++) begin
      int idx = loc - 6 + j;
      s[j] = (idx >= 0) ? fr[idx] : 4'h0;
    end
    return {s[1], s[0], s[3], s[2], s[5], s[4]};
  endfunction

  function automatic bit exp_match(input int n, input int loc, input logic [23:0] pat,
                                   input logic [23:0] msk, input bit en);
    if (!en || n < loc) return 1'b0;
    return (((window_of(loc) ^ pat) & ~msk) == 24'h0);
  endfunction

  // Timestamp monitor (R10, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (sfd_done) exp_ts = time_now;
      if (ts_valid) begin
        ts_cnt++;
        chk(ts_time == exp_ts, "R10", "ts_time at ts_valid", ts_time, exp_ts);
        chk(match_flag == 1'b1, "R11", "match_flag with ts_valid", match_flag, 1);
      end
    end
  end

  task automatic run_frame(input int n, input int loc, input logic [23:0] pat,
                           input logic [23:0] msk, input bit en, input bit gaps,
                           input bit stray, input string tag);
    bit em;
    cfg_enable = en; cfg_loc = 8'(loc);
    {cfg_pat_hi, cfg_pat_lo} = pat; {cfg_msk_hi, cfg_msk_lo} = msk;
    @(posedge clk); #1;
    frm_start = 1;
    nib_valid = 1; nib_data = 4'hF;  // ignored during start (R9)
    @(posedge clk); #1;
    frm_start = 0; nib_valid = 0; sfd_done = 1;
    @(negedge clk);
    chk(match_flag == 1'b0, "R9", {tag, " flag cleared by start"}, match_flag, 0);
    chk(nib_ready == 1'b1, "R1", {tag, " ready"}, nib_ready, 1);
    ts_cnt = 0;
    @(posedge clk); #1;
    sfd_done = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        nib_valid = 0;
        @(posedge clk); #1;
      end
      nib_valid = 1; nib_data = fr[i];
      @(posedge clk); #1;
    end
    nib_valid = 0; frm_end = 1;
    @(posedge clk); #1;
    frm_end = 0;
    if (stray) begin
      nib_valid = 1; nib_data = 4'hA;
      repeat (8) @(posedge clk);
      #1; nib_valid = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    em = exp_match(n, loc, pat, msk, en);
    chk(match_flag == em, "R2", {tag, " match_flag"}, match_flag, em);
    chk(ts_cnt == (em ? 1 : 0), "R11", {tag, " ts_valid pulses"}, ts_cnt, em ? 1 : 0);
    chk(ts_time == exp_ts, "R10", {tag, " ts_time held"}, ts_time, exp_ts);
  endtask

  task automatic put_msg(input logic [3:0] type_nib);
    for (int i = 0; i < 64; i++) fr[i] = 4'($urandom);
    fr[24] = 4'h8; fr[25] = 4'h8; fr[26] = 4'h7; fr[27] = 4'hF;
    fr[28] = type_nib; fr[29] = 4'h1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(match_flag == 0, "R9", "reset match_flag", match_flag, 0);
    chk(ts_valid == 0, "R11", "reset ts_valid", ts_valid, 0);
    chk(nib_ready == 1, "R1", "reset ready", nib_ready, 1);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ts_time == 0, "R10", "reset ts_time", ts_time, 0);

    // R2 R3 R5: message-type pattern at nibbles 24..29
    put_msg(4'h0);
    run_frame(40, 30, 24'h88F710, 24'h0, 1, 0, 0, "R3 msg exact");
    chk(match_flag == 1, "R3", "msg frame matched", match_flag, 1);
    run_frame(40, 29, 24'h88F710, 24'h0, 1, 0, 0, "R2 loc off by one");
    // R4: a changed type nibble fails exact and passes under mask
    put_msg(4'h3);
    run_frame(40, 30, 24'h88F710, 24'h0, 1, 0, 0, "R4 exact miss");
    chk(match_flag == 0, "R4", "exact miss", match_flag, 0);
    run_frame(40, 30, 24'h88F710, 24'h00000F, 1, 1, 0, "R4 masked hit");
    chk(match_flag == 1, "R4", "masked hit", match_flag, 1);
    // R5: high byte differs
    put_msg(4'h0);
    run_frame(40, 30, 24'h89F710, 24'h0, 1, 0, 0, "R5 high byte");
    chk(match_flag == 0, "R5", "high byte miss", match_flag, 0);
    // R6: disabled
    run_frame(40, 30, 24'h88F710, 24'h0, 0, 0, 0, "R6 disabled");
    chk(match_flag == 0, "R6", "disabled", match_flag, 0);
    // R7: location 0, full mask
    run_frame(0, 0, 24'h123456, 24'hFFFFFF, 1, 0, 0, "R7 empty");
    chk(match_flag == 1, "R7", "empty frame matched", match_flag, 1);
    run_frame(10, 0, 24'h0, 24'hFFFFFF, 1, 1, 0, "R7 short");
    // R8: frame shorter than location, stray nibbles after end
    run_frame(29, 30, 24'h88F710, 24'hFFFFFF, 1, 0, 1, "R8 short");
    chk(match_flag == 0, "R8", "short frame", match_flag, 0);
    // exact-length boundary; R12 stray nibbles after the compare
    run_frame(30, 30, 24'h88F710, 24'h0, 1, 0, 1, "R12 exact length");
    chk(match_flag == 1, "R12", "exact length kept", match_flag, 1);

    // random frames
    for (int k = 0; k < 300; k++) begin
      int n, loc;
      logic [23:0] pat, msk;
      for (int i = 0; i < 64; i++) fr[i] = 4'($urandom);
      n = $urandom % 48;
      loc = $urandom % 48;
      msk = ($urandom % 2) ? 24'h0 : 24'($urandom) & 24'($urandom);
      pat = window_of(loc);
      if ($urandom % 3 == 0) pat ^= 24'(1 << ($urandom % 24));
      run_frame(n, loc, pat, msk, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                "R12 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule